// File: doc/BRIEF.md
# Flash Write-and-Poll Controller

This block is the host-side master for an asynchronous parallel NOR flash. A client hands it one high-level request: program a single word, erase a sector, erase a block, or erase the entire array. The controller then drives the standard unlock command writes for that request as a series of bus cycles. After the last command write it reads the target location repeatedly until the flash reports that the internal operation has ended. It finishes with a single result pulse that carries a pass or fail flag.

Bus pin timing is abstracted away. The controller presents one transfer at a time on a simple valid/ready interface, and read data returns in the same cycle in which the transfer is accepted. Completion is detected by one of two methods, chosen by `poll_toggle` at request time. In data-polling mode the controller watches bit 7 of the status. In toggle mode it watches whether bit 6 keeps alternating. A status read can land at the same moment the flash finishes, so a detected completion is not trusted at once: two further confirmation reads must both look good, and otherwise polling resumes. Each operation type has its own polling time limit, set in clock cycles by a parameter. The defaults are twice the typical operation time at 100 MHz.

The state machine has seven states:
- `ST_IDLE`: waiting for a request.
- `ST_UNLOCK`: issuing the command writes.
- `ST_POLL_A`: first status read.
- `ST_POLL_B`: toggle-mode comparison reads.
- `ST_CONF_A`: first confirmation read.
- `ST_CONF_B`: second confirmation read.
- `ST_REPORT`: the result cycle.

Its transitions are:
- IDLE to UNLOCK when a request arrives.
- UNLOCK to itself after each accepted write, and to POLL_A after the final write.
- POLL_A to CONF_A in data mode once bit 7 matches, or to POLL_B in toggle mode.
- POLL_B to CONF_A once bit 6 repeats.
- CONF_A to CONF_B on a good read.
- CONF_B to REPORT with pass on a good read.
- Either CONF state back to POLL_A (data mode) or POLL_B (toggle mode) on a bad read.
- Any polling or confirmation state to REPORT with fail when the time limit expires.
- REPORT to IDLE.

Top module: `flash_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `bus_valid` are low and `req_ready` is high.
- R2: A request is taken only while `req_ready` is high (idle). A `req_valid` pulse seen while busy starts nothing: no extra bus writes and no extra `done`.
- R3: With `req_op` = 0 (program), exactly four writes are issued, in this order: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then `req_data` to `req_addr`.
- R4: With `req_op` = 1 (sector), 2 (block) or 3 (chip), exactly six writes are issued. The first five are 00AAh@5555h, 0055h@2AAAh, 0080h@5555h, 00AAh@5555h and 0055h@2AAAh. The sixth is 0030h@`req_addr` for a sector, 0050h@`req_addr` for a block, or 0010h@5555h for the whole chip.
- R5: A bus cycle presented while `bus_ready` is low stays presented, with its address, direction and write data unchanged, until it is accepted. The only exception is a pending read abandoned by a timeout.
- R6: Every status read is addressed to `req_addr`.
- R7: With `poll_toggle` = 0, completion is detected when bit 7 of a read equals the expected bit 7. The expected word is `req_data` for a program and all ones for any erase.
- R8: With `poll_toggle` = 1, completion is detected when bit 6 of a read equals bit 6 of the previous read.
- R9: After a detection, two further reads are made. Each must be good: in data mode the whole word equals the expected word, and in toggle mode bit 6 equals the previous read. Success is declared only if both are good; a bad one resumes polling.
- R10: If polling for a program, sector, block or chip operation lasts `TMO_PROG`, `TMO_SECT`, `TMO_BLOCK` or `TMO_CHIP` cycles respectively, the controller reports fail (`pass` = 0) and returns to idle.
- R11: `busy` is high from the cycle of the first command write up to and including the `done` cycle, and low in the cycle after it.
- R12: `done` is a single-cycle pulse, exactly one per accepted request, and `pass` is valid alongside it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Word, sector or block address; also the status read address |
| req_data | input | DW | Word to program |
| poll_toggle | input | 1 | 0 data-polling, 1 toggle-bit completion detection |
| req_ready | output | 1 | High when idle and able to take a request |
| bus_valid | output | 1 | Bus transfer presented |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus word address |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Transfer accepted this cycle |
| bus_rdata | input | DW | Read data, valid in the accepting cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Result flag, valid with `done` |

## Verification
The hardest situation to reach from the ports is a completion that is detected but then contradicted by a confirmation read, as happens when a status read races the end of the internal operation. The bench's flash model counts status reads rather than cycles. It can serve one corrupted word, with bits 7 and 6 flipped, exactly on the third read after the operation ends, which is always a confirmation read in both detection modes. The bench then checks that polling resumed, that the total read count matches, and that the result is still a pass. Stalls on `bus_ready` every fourth cycle exercise the hold rule throughout.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG  = 2'd0,
        OP_SECT  = 2'd1,
        OP_BLOCK = 2'd2,
        OP_CHIP  = 2'd3
    } flash_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK,
        ST_POLL_A,
        ST_POLL_B,
        ST_CONF_A,
        ST_CONF_B,
        ST_REPORT
    } ctl_state_e;

    localparam int unsigned STEP_W    = 3;
    localparam int unsigned PROG_LEN  = 4;
    localparam int unsigned ERASE_LEN = 6;

    localparam logic [14:0] CMD_ADR_HI = 15'h5555;
    localparam logic [14:0] CMD_ADR_LO = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] KEY_PROG   = 8'hA0;
    localparam logic [7:0] KEY_ERASE  = 8'h80;
    localparam logic [7:0] KEY_SECT   = 8'h30;
    localparam logic [7:0] KEY_BLOCK  = 8'h50;
    localparam logic [7:0] KEY_CHIP   = 8'h10;

endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int unsigned AW = 19,
    parameter int unsigned DW = 16
) (
    input  logic              en,
    input  flash_op_e         op,
    input  logic [STEP_W-1:0] step,
    input  logic [AW-1:0]     tgt_addr,
    input  logic [DW-1:0]     tgt_data,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              last
);

    localparam logic [AW-1:0] ADR_HI = AW'(CMD_ADR_HI);
    localparam logic [AW-1:0] ADR_LO = AW'(CMD_ADR_LO);

    logic [STEP_W-1:0] seq_len;

    always_comb begin
        seq_len = (op == OP_PROG) ? STEP_W'(PROG_LEN) : STEP_W'(ERASE_LEN);
        last    = (step == seq_len - STEP_W'(1));
        wr_addr = '0;
        wr_data = '0;
        case (step)
            3'd0: begin wr_addr = ADR_HI; wr_data = DW'(KEY_FIRST);  end
            3'd1: begin wr_addr = ADR_LO; wr_data = DW'(KEY_SECOND); end
            3'd2: begin
                wr_addr = ADR_HI;
                wr_data = (op == OP_PROG) ? DW'(KEY_PROG) : DW'(KEY_ERASE);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                end else begin
                    wr_addr = ADR_HI;
                    wr_data = DW'(KEY_FIRST);
                end
            end
            3'd4: begin wr_addr = ADR_LO; wr_data = DW'(KEY_SECOND); end
            3'd5: begin
                unique case (op)
                    OP_SECT:  begin wr_addr = tgt_addr; wr_data = DW'(KEY_SECT);  end
                    OP_BLOCK: begin wr_addr = tgt_addr; wr_data = DW'(KEY_BLOCK); end
                    OP_CHIP:  begin wr_addr = ADR_HI;   wr_data = DW'(KEY_CHIP);  end
                    default:  begin wr_addr = '0;       wr_data = '0;             end
                endcase
            end
            default: begin wr_addr = '0; wr_data = '0; end
        endcase
    end

    // R3 / R4: the sequencer never walks past the command length
    always_comb begin
        assert_step_range_R4: assert (!en || (step < seq_len));
    end

endmodule

// File: rtl/flash_status_eval.sv
module flash_status_eval #(
    parameter int unsigned DW = 16
) (
    input  logic          toggle_mode,
    input  logic          confirm,
    input  logic [DW-1:0] expect_word,
    input  logic [DW-1:0] rd_word,
    input  logic          prev_bit6,
    output logic          good
);

    always_comb begin
        if (toggle_mode) begin
            good = (rd_word[6] == prev_bit6);
        end else if (confirm) begin
            good = (rd_word == expect_word);
        end else begin
            good = (rd_word[7] == expect_word[7]);
        end
    end

endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R10: the polling window never overruns its limit
    assert_tmo_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int unsigned AW        = 19,
    parameter int unsigned DW        = 16,
    // twice the typical duration, counted in 100 MHz cycles
    parameter int unsigned TMO_PROG  = 5600,
    parameter int unsigned TMO_SECT  = 7200000,
    parameter int unsigned TMO_BLOCK = 7200000,
    parameter int unsigned TMO_CHIP  = 28000000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    input  logic          poll_toggle,
    output logic          req_ready,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          busy,
    output logic          done,
    output logic          pass
);

    localparam int unsigned TMO_M1  = (TMO_PROG > TMO_SECT) ? TMO_PROG : TMO_SECT;
    localparam int unsigned TMO_M2  = (TMO_BLOCK > TMO_CHIP) ? TMO_BLOCK : TMO_CHIP;
    localparam int unsigned TMO_MAX = (TMO_M1 > TMO_M2) ? TMO_M1 : TMO_M2;
    localparam int unsigned CW      = $clog2(TMO_MAX + 1);

    ctl_state_e        state_q, state_d;
    flash_op_e         op_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     data_q;
    logic              mode_q;
    logic [STEP_W-1:0] step_q, step_d;
    logic              prev6_q, prev6_d;
    logic              pass_q, pass_d;

    logic [AW-1:0]     rom_addr;
    logic [DW-1:0]     rom_data;
    logic              rom_last;
    logic              rom_en;
    logic              xfer;
    logic              good;
    logic              polling;
    logic              confirming;
    logic              tmo;
    logic [CW-1:0]     tmo_limit;
    logic [DW-1:0]     expect_word;
    ctl_state_e        resume_st;

    // ---------------- sub-blocks ----------------
    assign rom_en = (state_q == ST_UNLOCK);

    flash_cmd_rom #(.AW(AW), .DW(DW)) u_rom (
        .en       (rom_en),
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (rom_addr),
        .wr_data  (rom_data),
        .last     (rom_last)
    );

    assign confirming  = (state_q == ST_CONF_A) || (state_q == ST_CONF_B);
    assign polling     = (state_q == ST_POLL_A) || (state_q == ST_POLL_B) || confirming;
    assign expect_word = (op_q == OP_PROG) ? data_q : '1;
    assign resume_st   = mode_q ? ST_POLL_B : ST_POLL_A;

    flash_status_eval #(.DW(DW)) u_eval (
        .toggle_mode (mode_q),
        .confirm     (confirming),
        .expect_word (expect_word),
        .rd_word     (bus_rdata),
        .prev_bit6   (prev6_q),
        .good        (good)
    );

    always_comb begin
        unique case (op_q)
            OP_PROG:  tmo_limit = CW'(TMO_PROG);
            OP_SECT:  tmo_limit = CW'(TMO_SECT);
            OP_BLOCK: tmo_limit = CW'(TMO_BLOCK);
            OP_CHIP:  tmo_limit = CW'(TMO_CHIP);
            default:  tmo_limit = CW'(TMO_PROG);
        endcase
    end

    flash_poll_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rom_en),
        .run     (polling),
        .limit   (tmo_limit),
        .expired (tmo)
    );

    assign xfer = bus_valid && bus_ready;

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        prev6_d = prev6_q;
        pass_d  = pass_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_UNLOCK;
                    step_d  = '0;
                    pass_d  = 1'b0;
                end
            end
            ST_UNLOCK: begin
                if (xfer) begin
                    if (rom_last) state_d = ST_POLL_A;
                    else          step_d  = step_q + STEP_W'(1);
                end
            end
            ST_POLL_A: begin
                if (tmo) begin
                    state_d = ST_REPORT;
                    pass_d  = 1'b0;
                end else if (xfer) begin
                    prev6_d = bus_rdata[6];
                    if (mode_q)    state_d = ST_POLL_B;
                    else if (good) state_d = ST_CONF_A;
                end
            end
            ST_POLL_B: begin
                if (tmo) begin
                    state_d = ST_REPORT;
                    pass_d  = 1'b0;
                end else if (xfer) begin
                    prev6_d = bus_rdata[6];
                    if (good) state_d = ST_CONF_A;
                end
            end
            ST_CONF_A: begin
                if (tmo) begin
                    state_d = ST_REPORT;
                    pass_d  = 1'b0;
                end else if (xfer) begin
                    prev6_d = bus_rdata[6];
                    state_d = good ? ST_CONF_B : resume_st;
                end
            end
            ST_CONF_B: begin
                if (tmo) begin
                    state_d = ST_REPORT;
                    pass_d  = 1'b0;
                end else if (xfer) begin
                    prev6_d = bus_rdata[6];
                    if (good) begin
                        state_d = ST_REPORT;
                        pass_d  = 1'b1;
                    end else begin
                        state_d = resume_st;
                    end
                end
            end
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            prev6_q <= 1'b0;
            pass_q  <= 1'b0;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            prev6_q <= prev6_d;
            pass_q  <= pass_d;
            if (state_q == ST_IDLE && req_valid) begin
                op_q   <= flash_op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                mode_q <= poll_toggle;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_REPORT);
        pass      = pass_q;
        bus_valid = rom_en || polling;
        bus_write = rom_en;
        bus_addr  = rom_en ? rom_addr : addr_q;
        bus_wdata = rom_en ? rom_data : '0;
    end

    // ---------------- assertions ----------------
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_busy_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready && !tmo) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

    assert_req_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q) && $stable(mode_q)));

    assert_tmo_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> (done && !pass));

endmodule

// File: tb/sim_flash_seq_ctrl.sv
`timescale 1ns/1ps
module sim_flash_seq_ctrl;

    localparam int AW = 19;
    localparam int DW = 16;
    localparam int TP = 300;
    localparam int TS = 400;
    localparam int TB = 500;
    localparam int TC = 600;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic          poll_toggle;
    logic          req_ready;
    logic          bus_valid, bus_write, bus_ready;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          busy, done, pass;

    always #2 clk = ~clk;

    flash_seq_ctrl #(.AW(AW), .DW(DW), .TMO_PROG(TP), .TMO_SECT(TS),
                     .TMO_BLOCK(TB), .TMO_CHIP(TC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .poll_toggle(poll_toggle),
        .req_ready(req_ready), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .pass(pass)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic        tog;
        logic        hic;
        logic        hang;
        logic [18:0] addr;
        logic [15:0] data;
        logic [7:0]  nbusy;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 19'h12345, 16'hBEEF, 8'd5},
        '{2'd0, 1'b1, 1'b0, 1'b0, 19'h00777, 16'h1234, 8'd7},
        '{2'd1, 1'b0, 1'b0, 1'b0, 19'h3F800, 16'h0000, 8'd9},
        '{2'd2, 1'b1, 1'b0, 1'b0, 19'h48000, 16'h0000, 8'd4},
        '{2'd3, 1'b0, 1'b0, 1'b0, 19'h00000, 16'h0000, 8'd12},
        '{2'd0, 1'b0, 1'b1, 1'b0, 19'h00040, 16'h0055, 8'd3},
        '{2'd1, 1'b1, 1'b1, 1'b0, 19'h10800, 16'h0000, 8'd6},
        '{2'd2, 1'b0, 1'b0, 1'b1, 19'h70000, 16'h0000, 8'd0},
        '{2'd0, 1'b1, 1'b0, 1'b1, 19'h00abc, 16'h5A5A, 8'd0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 19'h7FFFF, 16'h00FF, 8'd0}
    };

    // ---------------- flash model ----------------
    logic        m_clr = 1'b0;
    logic [1:0]  m_op = 2'd0;
    logic [18:0] m_addr = '0;
    logic [15:0] m_data = '0;
    logic        m_hic = 1'b0;
    logic [31:0] m_nb_load = '0;
    logic [31:0] busy_left = '0;
    logic        tog = 1'b0;
    int          post = 0;
    logic        hic_used = 1'b0;
    int          wcnt = 0, rcnt = 0, raddr_err = 0;
    logic [18:0] wa [8];
    logic [15:0] wd [8];
    int          cyc = 0, last_wr_cyc = 0;
    logic [1:0]  rdy_cnt = 2'd0;
    int          m_len;
    logic [15:0] true_word;

    assign m_len     = (m_op == 2'd0) ? 4 : 6;
    assign bus_ready = (rdy_cnt != 2'd2);
    assign true_word = (m_op == 2'd0) ? m_data : 16'hFFFF;

    always_comb begin
        if (busy_left != 0) begin
            bus_rdata    = true_word;
            bus_rdata[7] = (m_op == 2'd0) ? ~m_data[7] : 1'b0;
            bus_rdata[6] = tog;
        end else if (m_hic && !hic_used && post == 2) begin
            bus_rdata = true_word ^ 16'h00C0;
        end else begin
            bus_rdata = true_word;
        end
    end

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rdy_cnt <= rdy_cnt + 2'd1;
        if (m_clr) begin
            wcnt <= 0; rcnt <= 0; raddr_err <= 0; busy_left <= '0;
            tog <= 1'b0; post <= 0; hic_used <= 1'b0;
        end else if (bus_valid && bus_ready) begin
            if (bus_write) begin
                if (wcnt < 8) begin
                    wa[wcnt] <= bus_addr;
                    wd[wcnt] <= bus_wdata;
                end
                wcnt        <= wcnt + 1;
                last_wr_cyc <= cyc;
                if (wcnt + 1 == m_len) busy_left <= m_nb_load;
            end else begin
                rcnt <= rcnt + 1;
                if (bus_addr != m_addr) raddr_err <= raddr_err + 1;
                if (busy_left != 0) begin
                    busy_left <= busy_left - 1;
                    tog       <= ~tog;
                end else begin
                    if (m_hic && !hic_used && post == 2) hic_used <= 1'b1;
                    post <= post + 1;
                end
            end
        end
    end

    // ---------------- monitors ----------------
    int          hold_err = 0, done_cnt = 0;
    logic        lv = 1'b0, lr = 1'b1, lw = 1'b0;
    logic [18:0] la = '0;
    logic [15:0] ld = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (lv && !lr && !done &&
                !(bus_valid && bus_addr == la && bus_write == lw && bus_wdata == ld))
                hold_err++;
            if (done) done_cnt++;
        end
        lv = bus_valid; lr = bus_ready; la = bus_addr; lw = bus_write; ld = bus_wdata;
    end

    // ---------------- checking ----------------
    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] exp_a(input logic [1:0] op, input int i,
                                          input logic [18:0] a);
        if (i == 3 && op == 2'd0) return a;
        if (i == 5) return (op == 2'd3) ? 19'h05555 : a;
        return (i == 1 || i == 4) ? 19'h02AAA : 19'h05555;
    endfunction

    function automatic logic [15:0] exp_d(input logic [1:0] op, input int i,
                                          input logic [15:0] d);
        case (i)
            0: return 16'h00AA;
            1: return 16'h0055;
            2: return (op == 2'd0) ? 16'h00A0 : 16'h0080;
            3: return (op == 2'd0) ? d : 16'h00AA;
            4: return 16'h0055;
            default: return (op == 2'd1) ? 16'h0030 : (op == 2'd2) ? 16'h0050 : 16'h0010;
        endcase
    endfunction

    function automatic int tmo_of(input logic [1:0] op);
        case (op)
            2'd0: return TP;
            2'd1: return TS;
            2'd2: return TB;
            default: return TC;
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input bit poke);
        int len, to, bad_busy, lat, dn0, t;
        logic got_pass;
        len = (v.op == 2'd0) ? 4 : 6;
        @(negedge clk);
        m_op = v.op; m_addr = v.addr; m_data = v.data; m_hic = v.hic;
        m_nb_load = v.hang ? 32'hFFFF_FFFF : {24'd0, v.nbusy};
        m_clr = 1'b1;
        @(negedge clk);
        m_clr = 1'b0;
        check(req_ready, "R2 idle ready before request", {31'd0, req_ready}, 1);
        req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
        poll_toggle = v.tog;
        dn0 = done_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        to = 0; bad_busy = 0;
        while (!done && to < 5000) begin
            if (!busy) bad_busy++;
            if (poke && to == 2) begin req_valid = 1'b1; req_op = 2'd3; end
            if (poke && to == 3) req_valid = 1'b0;
            @(negedge clk);
            to++;
        end
        check(to < 5000, "R12 done arrives", to, 5000);
        got_pass = pass;
        lat = cyc - last_wr_cyc;
        check(bad_busy == 0, "R11 busy held until done", bad_busy, 0);
        check(busy, "R11 busy high in done cycle", {31'd0, busy}, 1);
        @(negedge clk);
        check(!done, "R12 done is one cycle", {31'd0, done}, 0);
        check(!busy, "R11 busy released after done", {31'd0, busy}, 0);
        if (v.hang)
            check(got_pass == 1'b0, "R10 timeout reports fail", {31'd0, got_pass}, 0);
        else if (v.tog)
            check(got_pass == 1'b1, "R8 toggle completion passes", {31'd0, got_pass}, 1);
        else
            check(got_pass == 1'b1, "R7 data-poll completion passes", {31'd0, got_pass}, 1);
        check(wcnt == len, (v.op == 2'd0) ? "R3 write count" : "R4 write count", wcnt, len);
        for (int k = 0; k < len; k++) begin
            check(wa[k] == exp_a(v.op, k, v.addr),
                  (v.op == 2'd0) ? "R3 write address" : "R4 write address",
                  {13'd0, wa[k]}, {13'd0, exp_a(v.op, k, v.addr)});
            check(wd[k] == exp_d(v.op, k, v.data),
                  (v.op == 2'd0) ? "R3 write data" : "R4 write data",
                  {16'd0, wd[k]}, {16'd0, exp_d(v.op, k, v.data)});
        end
        check(raddr_err == 0, "R6 reads hit target address", raddr_err, 0);
        if (!v.hang && !v.tog)
            check(rcnt == v.nbusy + (v.hic ? 6 : 3), "R9 data-mode read count",
                  rcnt, v.nbusy + (v.hic ? 6 : 3));
        if (!v.hang && v.tog)
            check(rcnt >= v.nbusy + 3, "R8 toggle reads cover busy time", rcnt, v.nbusy + 3);
        if (v.hic)
            check(hic_used, "R9 bad confirm read resumed polling", {31'd0, hic_used}, 1);
        if (v.hang)
            check(lat >= tmo_of(v.op) && lat <= tmo_of(v.op) + 2, "R10 timeout latency",
                  lat, tmo_of(v.op) + 1);
        check(hold_err == 0, "R5 stalled cycle held", hold_err, 0);
        check(done_cnt == dn0 + 1, "R12 exactly one done", done_cnt - dn0, 1);
        if (poke) begin
            for (t = 0; t < 12; t++) @(negedge clk);
            check(!busy, "R2 request while busy started nothing", {31'd0, busy}, 0);
            check(wcnt == len, "R2 no extra writes", wcnt, len);
            check(done_cnt == dn0 + 1, "R2 no extra done", done_cnt - dn0, 1);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 150000 expected less");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0; req_addr = '0;
        req_data = '0; poll_toggle = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_valid && req_ready, "R1 outputs in reset",
              {28'd0, busy, done, bus_valid, req_ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !bus_valid && req_ready, "R1 outputs after reset",
              {28'd0, busy, done, bus_valid, req_ready}, 1);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // directed: a request during a busy program is ignored (R2)
        run_vec('{2'd0, 1'b0, 1'b0, 1'b0, 19'h02222, 16'h8001, 8'd20}, 1'b1);
        // directed: chip erase in toggle mode with immediate completion (R8, R4)
        run_vec('{2'd3, 1'b1, 1'b0, 1'b0, 19'h00100, 16'h0000, 8'd0}, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule